// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns bytes, or 9-bit words, written by a host into asynchronous serial frames on a single output pin. Ahead of the transmit shifter sits a one-word holding register. The host can therefore queue the next word while the current frame is still leaving the pin. When the current stop bit ends, the queued word follows with no idle time between frames. Two status outputs report the state of the two stages: one shows that the holding stage can accept a word, the other shows that the shifter is idle. An interrupt request follows the holding-stage flag when its enable bit is set.

The host writes four byte-wide locations:

| Address | Location | Contents |
|---|---|---|
| 0 | Mode/status | bit 0 ninth-bit value, bit 2 fast prescale, bit 4 synchronous mode, bit 5 transmit enable, bit 6 9-bit format |
| 1 | Divisor | 8-bit baud divisor |
| 2 | Data | data word |
| 3 | Auxiliary | bit 0 port enable, bit 1 interrupt enable |

The mode/status location is always visible on `ctl_stat`. On that output, bit 1 reports that the shifter is idle, and bits 3 and 7 read 0.

Frames are sent only when three conditions hold at once: the port is enabled, synchronous mode is off, and transmit is enabled. In that state each serial bit lasts (divisor+1)×16 clocks with fast prescale selected, and (divisor+1)×64 clocks without it.

Top module: `dbuf_uart_tx`

## Requirements
- R1: After reset, `ctl_stat` reads 8'h02, `tx_pin` is 1, `hold_empty` is 0, `shift_empty` is 1 and `tx_irq` is 0. Writes to bits 1, 3 and 7 of address 0 do not change what `ctl_stat` shows in those bits.
- R2: `hold_empty` is 0 while transmit enable (address 0 bit 5) is 0. With the port enabled, setting transmit enable raises `hold_empty` right after the write.
- R3: A write to address 2 clears `hold_empty` right after the write edge. If the shifter is idle, the word moves into the shifter on the next clock. `hold_empty` then returns to 1 and `shift_empty` falls to 0.
- R4: A frame is a 0 start bit, then the data bits least significant first, then a 1 stop bit.
- R5: Each bit lasts (divisor+1)×16 clocks when address 0 bit 2 is 1, and (divisor+1)×64 clocks when it is 0.
- R6: When address 0 bit 6 is 1, a ninth data bit follows data bit 7. Its value is taken from address 0 bit 0 at the moment the data word is written; later changes to bit 0 do not affect that word.
- R7: `shift_empty` is 1 while no frame is shifting and 0 during a frame. It returns to 1 on the clock that ends the stop bit. `tx_pin` is 1 whenever the shifter is idle.
- R8: A word written while a frame is shifting is held, with `hold_empty` at 0. It enters the shifter on the clock that ends the current stop bit, so its start bit follows with no gap and `shift_empty` stays 0. `hold_empty` then returns to 1.
- R9: `tx_irq` equals `hold_empty` when the interrupt enable (address 3 bit 1) is 1, and is 0 otherwise.
- R10: With synchronous mode set (address 0 bit 4) or the port disabled (address 3 bit 0 clear), a data write starts no frame, `tx_pin` stays 1 and `shift_empty` stays 1.
- R11: Clearing transmit enable in the middle of a frame drives `tx_pin` high right after the write. It returns the shifter to idle on the next clock and discards any held word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Host write location |
| wr_data | input | 8 | Host write data |
| tx_pin | output | 1 | Serial output, idles high |
| hold_empty | output | 1 | Holding register can accept a word |
| shift_empty | output | 1 | Shifter idle |
| tx_irq | output | 1 | Interrupt request |
| ctl_stat | output | 8 | Mode/status readback |

## Verification
Counting from the write edge of a data word, `hold_empty` falls immediately and the load into the shifter happens one clock later. Each bit of the frame then spans exactly T = (divisor+1)×prescale clocks, so bit i is driven from edge 1+i·T up to edge 1+(i+1)·T. The bench drives and samples on falling edges and keeps its own count of half-cycles since the write. It reads each bit at its midpoint, and it checks the start-bit and end-of-frame edges on the cycles just before and just after the transition. Effects of a mode write or an abort are checked half a cycle after the write for the pin and flags, and one cycle later for the shifter going idle.

// File: rtl/dbtx_pkg.sv
package dbtx_pkg;
   typedef enum logic [1:0] {
      LOC_MODE = 2'd0,
      LOC_DIV  = 2'd1,
      LOC_DATA = 2'd2,
      LOC_AUX  = 2'd3
   } dbtx_loc_e;

   localparam int MB_NVAL = 0;
   localparam int MB_IDLE = 1;
   localparam int MB_FAST = 2;
   localparam int MB_SYNC = 4;
   localparam int MB_TXEN = 5;
   localparam int MB_W9   = 6;

   localparam int AB_PEN  = 0;
   localparam int AB_IE   = 1;
endpackage

// File: rtl/dbtx_baud.sv
module dbtx_baud #(
   parameter int DIV_W     = 8,
   parameter int PRE_FAST  = 16,
   parameter int PRE_SLOW  = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             fast,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   localparam int PW = $clog2(PRE_SLOW);
   localparam logic [PW-1:0] LIM_F = PW'(PRE_FAST - 1);
   localparam logic [PW-1:0] LIM_S = PW'(PRE_SLOW - 1);

   if (PRE_FAST < 2 || PRE_SLOW < PRE_FAST) begin : g_bad_pre
      $error("dbtx_baud: prescale values out of range");
   end

   logic [PW-1:0]    pre_q;
   logic [DIV_W-1:0] cnt_q;
   logic [PW-1:0]    pre_lim;
   logic             pre_wrap;

   if (PRE_FAST == PRE_SLOW) begin : g_one_pre
      assign pre_lim = LIM_S;
   end else begin : g_two_pre
      assign pre_lim = fast ? LIM_F : LIM_S;
   end

   assign pre_wrap = (pre_q == pre_lim);
   assign tick     = run && pre_wrap && (cnt_q == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         cnt_q <= '0;
      end else if (!run) begin
         pre_q <= '0;
         cnt_q <= '0;
      end else if (pre_wrap) begin
         pre_q <= '0;
         cnt_q <= (cnt_q == div) ? '0 : cnt_q + 1'b1;
      end else begin
         pre_q <= pre_q + 1'b1;
      end
   end
endmodule

// File: rtl/dbtx_shift.sv
module dbtx_shift #(
   parameter int DW   = 8,
   parameter bit EXT9 = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          tick,
   input  logic          avail,
   input  logic [DW-1:0] ld_data,
   input  logic          ld_w9,
   input  logic          ld_nval,
   output logic          take,
   output logic          busy,
   output logic          txd
);
   localparam int FW = DW + 3;
   localparam int CW = $clog2(FW + 1);
   localparam logic [CW-1:0] LEN8 = CW'(DW + 2);
   localparam logic [CW-1:0] LEN9 = CW'(DW + 3);

   logic [FW-1:0] sreg_q;
   logic [CW-1:0] left_q;
   logic [FW-1:0] frame;
   logic [CW-1:0] flen;
   logic          last_bit;

   if (EXT9) begin : g_ext9
      assign frame = ld_w9 ? {1'b1, ld_nval, ld_data, 1'b0} : {2'b11, ld_data, 1'b0};
      assign flen  = ld_w9 ? LEN9 : LEN8;
   end else begin : g_fixed8
      logic unused_nine;
      assign unused_nine = ld_w9 ^ ld_nval;
      assign frame = {2'b11, ld_data, 1'b0};
      assign flen  = LEN8;
   end

   assign last_bit = tick && (left_q == CW'(1));
   assign take     = en && avail && (!busy || last_bit);
   assign txd      = (busy && en) ? sreg_q[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         sreg_q <= '1;
         left_q <= '0;
      end else if (!en) begin
         busy   <= 1'b0;
         sreg_q <= '1;
         left_q <= '0;
      end else if (take) begin
         busy   <= 1'b1;
         sreg_q <= frame;
         left_q <= flen;
      end else if (busy && tick) begin
         if (left_q == CW'(1)) begin
            busy   <= 1'b0;
            left_q <= '0;
         end else begin
            sreg_q <= {1'b1, sreg_q[FW-1:1]};
            left_q <= left_q - 1'b1;
         end
      end
   end
endmodule

// File: rtl/dbuf_uart_tx.sv
module dbuf_uart_tx #(
   parameter int DW       = 8,
   parameter int DIV_W    = 8,
   parameter int PRE_FAST = 16,
   parameter int PRE_SLOW = 64,
   parameter bit EXT9     = 1'b1,
   localparam int BW0     = (DW > 8) ? DW : 8,
   localparam int BW      = (DIV_W > BW0) ? DIV_W : BW0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    wr_addr,
   input  logic [BW-1:0] wr_data,
   output logic          tx_pin,
   output logic          hold_empty,
   output logic          shift_empty,
   output logic          tx_irq,
   output logic [7:0]    ctl_stat
);
   import dbtx_pkg::*;

   if (DW < 5) begin : g_bad_dw
      $error("dbuf_uart_tx: data width too small");
   end

   logic             m_nval, m_fast, m_sync, m_txen, m_w9;
   logic             a_pen, a_ie;
   logic [DIV_W-1:0] div_q;
   logic [DW-1:0]    hold_data;
   logic             hold_w9, hold_nval, hold_full;
   logic             en, take, busy, tick;
   dbtx_loc_e        loc;

   assign loc = dbtx_loc_e'(wr_addr);
   assign en  = a_pen && !m_sync && m_txen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         {m_nval, m_fast, m_sync, m_txen, m_w9} <= '0;
         {a_pen, a_ie} <= '0;
         div_q <= '0;
      end else if (wr_en) begin
         case (loc)
            LOC_MODE: begin
               m_nval <= wr_data[MB_NVAL];
               m_fast <= wr_data[MB_FAST];
               m_sync <= wr_data[MB_SYNC];
               m_txen <= wr_data[MB_TXEN];
               m_w9   <= wr_data[MB_W9];
            end
            LOC_DIV: div_q <= wr_data[DIV_W-1:0];
            LOC_AUX: begin
               a_pen <= wr_data[AB_PEN];
               a_ie  <= wr_data[AB_IE];
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_full <= 1'b0;
         hold_data <= '0;
         hold_w9   <= 1'b0;
         hold_nval <= 1'b0;
      end else if (!en) begin
         hold_full <= 1'b0;
      end else if (wr_en && loc == LOC_DATA) begin
         hold_full <= 1'b1;
         hold_data <= wr_data[DW-1:0];
         hold_w9   <= m_w9;
         hold_nval <= m_nval;
      end else if (take) begin
         hold_full <= 1'b0;
      end
   end

   dbtx_baud #(
      .DIV_W    (DIV_W),
      .PRE_FAST (PRE_FAST),
      .PRE_SLOW (PRE_SLOW)
   ) u_baud (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy && en),
      .fast  (m_fast),
      .div   (div_q),
      .tick  (tick)
   );

   dbtx_shift #(
      .DW   (DW),
      .EXT9 (EXT9)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (en),
      .tick    (tick),
      .avail   (hold_full),
      .ld_data (hold_data),
      .ld_w9   (hold_w9),
      .ld_nval (hold_nval),
      .take    (take),
      .busy    (busy),
      .txd     (tx_pin)
   );

   assign shift_empty = !busy;
   assign hold_empty  = m_txen && !hold_full;
   assign tx_irq      = hold_empty && a_ie;
   assign ctl_stat    = {1'b0, m_w9, m_txen, m_sync, 1'b0, m_fast, !busy, m_nval};
endmodule

// File: rtl/dbtx_chk.sv
module dbtx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tx_pin,
   input logic       hold_empty,
   input logic       shift_empty,
   input logic       tx_irq,
   input logic [7:0] ctl_stat
);
   p_idle_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      shift_empty |-> tx_pin);

   p_start_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(shift_empty) |-> !tx_pin);

   p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_irq |-> hold_empty);

   p_txen_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctl_stat[5]) |-> hold_empty);

   p_abort_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_stat[5] && !$past(ctl_stat[5])) |-> shift_empty);

   p_fixed_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_stat[7] && !ctl_stat[3]);

   p_idle_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_stat[1] == shift_empty);
endmodule

bind dbuf_uart_tx dbtx_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tx_pin      (tx_pin),
   .hold_empty  (hold_empty),
   .shift_empty (shift_empty),
   .tx_irq      (tx_irq),
   .ctl_stat    (ctl_stat)
);

// File: tb/dbuf_uart_tx_tb.sv
module dbuf_uart_tx_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       tx_pin, hold_empty, shift_empty, tx_irq;
   logic [7:0] ctl_stat;
   int checks = 0;
   int errors = 0;

   localparam logic [7:0] K_NVAL = 8'h01, K_FAST = 8'h04, K_SYNC = 8'h10,
                          K_TXEN = 8'h20, K_W9 = 8'h40;
   localparam logic [7:0] K_PEN = 8'h01, K_IE = 8'h02;

   always #10 clk = ~clk;

   dbuf_uart_tx dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .tx_pin(tx_pin), .hold_empty(hold_empty), .shift_empty(shift_empty),
      .tx_irq(tx_irq), .ctl_stat(ctl_stat)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic cap(inout int cur, input int t, input int i0, input int n,
                      inout logic [31:0] bits);
      for (int i = i0; i < i0 + n; i++) begin
         int tgt;
         tgt = 1 + i * t + t / 2;
         wait_n(tgt - cur);
         cur = tgt;
         bits[i] = tx_pin;
      end
   endtask

   task automatic t_reset;
      check("R1 reset ctl_stat", ctl_stat, 8'h02);
      check("R1 reset tx_pin", tx_pin, 1);
      check("R1 reset hold_empty", hold_empty, 0);
      check("R1 reset shift_empty", shift_empty, 1);
      check("R1 reset tx_irq", tx_irq, 0);
   endtask

   task automatic t_enable;
      wr(2'd3, K_PEN);
      check("R2 hold_empty with txen off", hold_empty, 0);
      wr(2'd0, K_TXEN | K_FAST);
      check("R2 hold_empty after txen", hold_empty, 1);
      wr(2'd0, K_TXEN | K_FAST | 8'h8A);
      check("R1 fixed bits readback", ctl_stat, 8'h26);
   endtask

   task automatic t_frame8;
      int cur;
      logic [31:0] bits = '0;
      wr(2'd1, 8'd0);
      wr(2'd2, 8'hA5);
      check("R3 hold_empty after write", hold_empty, 0);
      wait_n(1); cur = 1;
      check("R3 hold_empty after transfer", hold_empty, 1);
      check("R3 shift_empty falls", shift_empty, 0);
      cap(cur, 16, 0, 10, bits);
      check("R4 8-bit frame", bits[9:0], 32'h34A);
      wait_n(160 - cur);
      check("R7 busy before stop end", shift_empty, 0);
      wait_n(1);
      check("R7 idle after stop end", shift_empty, 1);
   endtask

   task automatic t_slow;
      wr(2'd0, K_TXEN);
      wr(2'd1, 8'd1);
      wr(2'd2, 8'h3D);
      wait_n(128);
      check("R5 slow start bit still low", tx_pin, 0);
      wait_n(1);
      check("R5 slow bit0 after 128 clocks", tx_pin, 1);
      wait_n(1280 - 129);
      check("R5 slow frame still busy", shift_empty, 0);
      wait_n(1);
      check("R5 slow frame done at 10x128", shift_empty, 1);
   endtask

   task automatic t_nine;
      int cur;
      logic [31:0] bits = '0;
      wr(2'd0, K_TXEN | K_FAST | K_W9 | K_NVAL);
      wr(2'd2, 8'h5A);
      cur = 0;
      cap(cur, 32, 0, 11, bits);
      check("R6 9-bit frame ninth=1", bits[10:0], 32'h6B4);
      wait_n(353 - cur);
      check("R6 9-bit frame length", shift_empty, 1);
      bits = '0;
      wr(2'd0, K_TXEN | K_FAST | K_W9);
      wr(2'd2, 8'h5A);
      wr(2'd0, K_TXEN | K_FAST | K_W9 | K_NVAL);
      cur = 1;
      cap(cur, 32, 0, 11, bits);
      check("R6 ninth captured at write", bits[10:0], 32'h4B4);
      wait_n(353 - cur);
   endtask

   task automatic t_b2b;
      int cur;
      logic [31:0] bits = '0;
      wr(2'd0, K_TXEN | K_FAST);
      wr(2'd1, 8'd0);
      wr(2'd2, 8'h81);
      wait_n(1);
      wr(2'd2, 8'h7E);
      cur = 2;
      check("R8 second word held", hold_empty, 0);
      cap(cur, 16, 0, 10, bits);
      wait_n(160 - cur);
      check("R8 still held before stop end", hold_empty, 0);
      wait_n(1); cur = 161;
      check("R8 hold released at stop end", hold_empty, 1);
      check("R8 no idle between frames", shift_empty, 0);
      cap(cur, 16, 10, 10, bits);
      check("R8 back-to-back bits", bits[19:0], (32'h2FC << 10) | 32'h302);
      wait_n(321 - cur);
      check("R8 both frames done", shift_empty, 1);
   endtask

   task automatic t_irq;
      wr(2'd3, K_PEN | K_IE);
      check("R9 irq follows empty", tx_irq, 1);
      wr(2'd2, 8'h11);
      check("R9 irq low while held", tx_irq, 0);
      wait_n(1);
      check("R9 irq back after transfer", tx_irq, 1);
      wr(2'd3, K_PEN);
      check("R9 irq masked", tx_irq, 0);
      wait_n(200);
   endtask

   task automatic t_abort;
      wr(2'd2, 8'h00);
      wait_n(48);
      check("R11 mid-frame pin low", tx_pin, 0);
      wr(2'd0, K_FAST);
      check("R11 pin high after disable", tx_pin, 1);
      wait_n(1);
      check("R11 shifter idle", shift_empty, 1);
      check("R2 hold_empty off with txen 0", hold_empty, 0);
      wr(2'd0, K_TXEN | K_FAST);
      wait_n(50);
      check("R11 no resumed frame", {tx_pin, shift_empty, hold_empty}, 3'b111);
   endtask

   task automatic t_blocked;
      int bad = 0;
      wr(2'd0, K_TXEN | K_FAST | K_SYNC);
      check("R10 sync readback", ctl_stat, 8'h36);
      wr(2'd2, 8'h00);
      for (int i = 0; i < 200; i++) begin
         if (!tx_pin || !shift_empty) bad++;
         @(negedge clk);
      end
      check("R10 sync mode sends nothing", bad, 0);
      wr(2'd0, K_TXEN | K_FAST);
      wr(2'd3, 8'h00);
      wr(2'd2, 8'h00);
      bad = 0;
      for (int i = 0; i < 200; i++) begin
         if (!tx_pin || !shift_empty) bad++;
         @(negedge clk);
      end
      check("R10 port off sends nothing", bad, 0);
   endtask

   initial begin
      wait_n(3);
      rst_n = 1'b1;
      wait_n(1);
      t_reset;
      t_enable;
      t_frame8;
      t_slow;
      t_nine;
      t_b2b;
      t_irq;
      t_abort;
      t_blocked;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule